// File: doc/BRIEF.md
# Connection Table Access Controller

The block guards a connection table whose entries are spread over eight 32-bit memory banks. Each entry takes one word in every bank, and its connection identifier selects it. A processor bus issues loads and stores. Before any bank is touched, the controller decodes each request and decides whether to allow it. Refused requests return a fault and leave the table unchanged.

Two facts decide the privilege of a bus access. The first is the address alias it arrives on. The table appears twice in the physical map: a system alias for kernel software and a shadow alias for user processes. The second is which process owns the page the access lands in. One page covers 32 connections and has an owner register. A user-alias access carries a process ID, which must match that owner. Write permission is decided per bank. Each bank belongs to one of three protection zones:
- high: written only by the hardware update port;
- moderate: written only from the system alias;
- low: written by anyone.

Reads are allowed in every zone.

A control region sits beside the table in each alias. It holds the page-owner registers, plus the address and reason code of the most recent refused access.

Top module: `ctac_top`

## Requirements
- R1: The bus word address is {alias, region, cid, bank}. Alias is the MSB: 0 is system, 1 is user shadow. Region: 0 is table, 1 is control. Bank is the low 3 bits. Each request produces exactly one response with `rsp_valid` in the following cycle. A read returns the word that an earlier allowed write stored at that cid and bank.
- R2: A system-alias write to a high-zone bank is refused with reason 3 and leaves the word unchanged. System-alias writes to moderate-zone and low-zone banks succeed. The default zone map is: banks 0 and 1 high, banks 2 to 5 moderate, banks 6 and 7 low.
- R3: A user-alias write to a moderate-zone or high-zone bank is refused with reason 1 and leaves the word unchanged. A user-alias write to a low-zone bank by the page owner succeeds.
- R4: User-alias reads by the page owner succeed in every zone.
- R5: A user-alias access whose `req_pid` differs from the owner of the addressed page is refused with reason 2. Any refused response returns `rsp_rdata` = 0.
- R6: When a user-alias write has both a wrong owner and a protected zone, the reported reason is 2.
- R7: Any user-alias access to the control region is refused with reason 4.
- R8: The hardware update port writes any bank, including high-zone banks. When it writes the same word in the same cycle as an allowed bus write, the hardware value is stored.
- R9: The control region is laid out as follows:
  - index p < number of pages: owner of page p, written from the system alias;
  - index = number of pages: address of the latest refused access;
  - index = number of pages + 1: its reason.

  Allowed accesses leave the fault address and fault reason unchanged.
- R10: After reset, table words, owners, fault address and fault reason all read 0, and `rsp_valid` is 0.
- R11: The page of a cid is cid / 32. Connections 31 and 32 therefore belong to different owners.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 for store, 0 for load |
| req_addr | input | 11 | Word address {alias, region, cid, bank} |
| req_wdata | input | 32 | Store data |
| req_pid | input | 8 | Process ID of the requester |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_fault | output | 1 | Previous request was refused |
| rsp_rdata | output | 32 | Load data, 0 for stores and refusals |
| hw_we | input | 1 | Hardware update port write enable |
| hw_cid | input | 6 | Hardware update connection ID |
| hw_bank | input | 3 | Hardware update bank |
| hw_wdata | input | 32 | Hardware update data |

## Verification
The hardest case to reach is a write collision. The hardware port and an allowed bus store must hit the same word in the same cycle, and the port alone must decide the result. The bench drives both in one cycle from a single task, then reads the word back through the system alias. A second hard case is the precedence between refusal reasons. To reach it, the bench first programs distinct owners for both pages. It then sends a user store that breaks both the owner rule and the zone rule, and reads the recorded reason back from the control region.

// File: rtl/ctac_pkg.sv
// Package: shared encodings for the connection table access controller.
// Assumes zone codes are two bits wide and reason codes three bits wide.
package ctac_pkg;

    typedef enum logic [1:0] {
        ZN_LOW  = 2'b00,
        ZN_MID  = 2'b01,
        ZN_HIGH = 2'b10
    } zone_e;

    typedef enum logic [2:0] {
        RSN_NONE  = 3'd0,
        RSN_ZONE  = 3'd1,
        RSN_OWNER = 3'd2,
        RSN_HIGH  = 3'd3,
        RSN_CTRL  = 3'd4
    } reason_e;

endpackage

// File: rtl/ctac_check.sv
// Permission check: combinational decision on one bus request.
// Assumes the caller has already looked up the owner of the addressed page.
// A refusal carries one reason. Reasons are ranked as follows:
//   control access from user, then owner mismatch, then zone.
module ctac_check
    import ctac_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int PID_W     = 8,
    parameter logic [2*NUM_BANKS-1:0] ZONE_MAP = 16'b00_00_01_01_01_01_10_10,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              valid,
    input  logic              write,
    input  logic              is_user,
    input  logic              is_ctrl,
    input  logic [BANK_W-1:0] bank,
    input  logic [PID_W-1:0]  pid,
    input  logic [PID_W-1:0]  page_owner,
    output logic              allow,
    output logic              refuse,
    output reason_e           reason
);

    zone_e zone;

    // Look up the protection zone of the addressed bank.
    always_comb begin
        zone = zone_e'(ZONE_MAP[bank*2 +: 2]);
    end

    // Rank the refusal reasons and pick one.
    always_comb begin
        reason = RSN_NONE;
        if (is_ctrl) begin
            if (is_user) reason = RSN_CTRL;
        end else if (is_user && (pid != page_owner)) begin
            reason = RSN_OWNER;
        end else if (write && zone == ZN_HIGH) begin
            reason = is_user ? RSN_ZONE : RSN_HIGH;
        end else if (write && is_user && zone == ZN_MID) begin
            reason = RSN_ZONE;
        end
    end

    // Qualify the decision with request presence.
    always_comb begin
        allow  = valid && (reason == RSN_NONE);
        refuse = valid && (reason != RSN_NONE);
    end

endmodule

// File: rtl/ctac_bank.sv
// One table bank: DEPTH words with a synchronous read port and two write ports.
// Assumes the hardware port must win a same-word collision, so it is written last.
module ctac_bank #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              hw_we,
    input  logic [AW-1:0]     hw_addr,
    input  logic [DATA_W-1:0] hw_wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store words: the later hardware write overrides a bus write to the same word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (bus_we) mem[bus_addr] <= bus_wdata;
            if (hw_we)  mem[hw_addr]  <= hw_wdata;
        end
    end

    // Registered read of the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/ctac_ctrl_regs.sv
// Control registers: per-page owners plus the latest fault address and reason.
// Assumes the caller only asserts own_we for allowed system-alias control stores.
module ctac_ctrl_regs
    import ctac_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PID_W     = 8,
    parameter int NUM_PAGES = 2,
    parameter int IDX_W     = 9,
    parameter int ADDR_W    = 11,
    localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              own_we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PAGE_W-1:0] look_page,
    output logic [PID_W-1:0]  look_owner,
    input  logic              flt_we,
    input  logic [ADDR_W-1:0] flt_addr_in,
    input  reason_e           flt_reason_in,
    output reason_e           flt_reason,
    output logic [DATA_W-1:0] rdata
);

    logic [PID_W-1:0]  owner [NUM_PAGES];
    logic [ADDR_W-1:0] flt_addr;
    logic              idx_is_owner;

    // Decode whether the control index names an owner register.
    always_comb begin
        idx_is_owner = idx < IDX_W'(NUM_PAGES);
    end

    // Owner registers, written by allowed system-alias control stores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PAGES; p++) owner[p] <= '0;
        end else if (own_we && idx_is_owner) begin
            owner[idx[PAGE_W-1:0]] <= wdata[PID_W-1:0];
        end
    end

    // Capture the address and reason of each refused access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_addr   <= '0;
            flt_reason <= RSN_NONE;
        end else if (flt_we) begin
            flt_addr   <= flt_addr_in;
            flt_reason <= flt_reason_in;
        end
    end

    // Owner lookup for the permission check.
    always_comb begin
        look_owner = owner[look_page];
    end

    // Readback mux for control-region loads.
    always_comb begin
        rdata = '0;
        if (idx_is_owner)
            rdata = {{(DATA_W-PID_W){1'b0}}, owner[idx[PAGE_W-1:0]]};
        else if (idx == IDX_W'(NUM_PAGES))
            rdata = {{(DATA_W-ADDR_W){1'b0}}, flt_addr};
        else if (idx == IDX_W'(NUM_PAGES + 1))
            rdata = {{(DATA_W-3){1'b0}}, flt_reason};
    end

endmodule

// File: rtl/ctac_top.sv
// Connection table access controller top.
// Decodes bus requests, checks alias privilege, page ownership and bank zone,
// then drives the banks and the control registers. Responses follow one cycle later.
// Assumes one bus request per cycle and a write-only hardware update port.
module ctac_top
    import ctac_pkg::*;
#(
    parameter int NUM_BANKS         = 8,
    parameter int DATA_W            = 32,
    parameter int CID_W             = 6,
    parameter int PID_W             = 8,
    parameter int ENTRIES_PER_PAGE  = 32,
    parameter logic [2*NUM_BANKS-1:0] ZONE_MAP = 16'b00_00_01_01_01_01_10_10
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid,
    input  logic                                   req_write,
    input  logic [CID_W+$clog2(NUM_BANKS)+1:0]     req_addr,
    input  logic [DATA_W-1:0]                      req_wdata,
    input  logic [PID_W-1:0]                       req_pid,
    output logic                                   rsp_valid,
    output logic                                   rsp_fault,
    output logic [DATA_W-1:0]                      rsp_rdata,
    input  logic                                   hw_we,
    input  logic [CID_W-1:0]                       hw_cid,
    input  logic [$clog2(NUM_BANKS)-1:0]           hw_bank,
    input  logic [DATA_W-1:0]                      hw_wdata
);

    localparam int BANK_W     = $clog2(NUM_BANKS);
    localparam int IDX_W      = CID_W + BANK_W;
    localparam int ADDR_W     = IDX_W + 2;
    localparam int DEPTH      = 1 << CID_W;
    localparam int PAGE_SHIFT = $clog2(ENTRIES_PER_PAGE);
    localparam int PAGE_W     = CID_W - PAGE_SHIFT;
    localparam int NUM_PAGES  = 1 << PAGE_W;

    logic                is_user, is_ctrl;
    logic [CID_W-1:0]    cid;
    logic [BANK_W-1:0]   bank;
    logic [IDX_W-1:0]    ctrl_idx;
    logic [PAGE_W-1:0]   page;
    logic [PID_W-1:0]    page_owner;
    logic                allow, refuse;
    reason_e             reason;
    reason_e             fault_reason_w;
    logic [DATA_W-1:0]   ctrl_rdata;
    logic [DATA_W-1:0]   bank_rdata [NUM_BANKS];
    logic                tbl_rd, ctrl_rd;
    logic                tbl_rd_q, ctrl_rd_q;
    logic [BANK_W-1:0]   bank_q;
    logic [DATA_W-1:0]   ctrl_rdata_q;

    // Split the bus address into alias, region, entry and bank fields.
    always_comb begin
        is_user  = req_addr[ADDR_W-1];
        is_ctrl  = req_addr[ADDR_W-2];
        ctrl_idx = req_addr[IDX_W-1:0];
        cid      = req_addr[IDX_W-1:BANK_W];
        bank     = req_addr[BANK_W-1:0];
        page     = cid[CID_W-1:PAGE_SHIFT];
    end

    ctac_check #(
        .NUM_BANKS (NUM_BANKS),
        .PID_W     (PID_W),
        .ZONE_MAP  (ZONE_MAP)
    ) check_i (
        .valid      (req_valid),
        .write      (req_write),
        .is_user    (is_user),
        .is_ctrl    (is_ctrl),
        .bank       (bank),
        .pid        (req_pid),
        .page_owner (page_owner),
        .allow      (allow),
        .refuse     (refuse),
        .reason     (reason)
    );

    ctac_ctrl_regs #(
        .DATA_W    (DATA_W),
        .PID_W     (PID_W),
        .NUM_PAGES (NUM_PAGES),
        .IDX_W     (IDX_W),
        .ADDR_W    (ADDR_W)
    ) regs_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .own_we        (allow && is_ctrl && req_write),
        .idx           (ctrl_idx),
        .wdata         (req_wdata),
        .look_page     (page),
        .look_owner    (page_owner),
        .flt_we        (refuse),
        .flt_addr_in   (req_addr),
        .flt_reason_in (reason),
        .flt_reason    (fault_reason_w),
        .rdata         (ctrl_rdata)
    );

    // Qualify allowed loads for each target.
    always_comb begin
        tbl_rd  = allow && !req_write && !is_ctrl;
        ctrl_rd = allow && !req_write &&  is_ctrl;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ctac_bank #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_we    (allow && req_write && !is_ctrl && bank == BANK_W'(b)),
            .bus_addr  (cid),
            .bus_wdata (req_wdata),
            .hw_we     (hw_we && hw_bank == BANK_W'(b)),
            .hw_addr   (hw_cid),
            .hw_wdata  (hw_wdata),
            .re        (tbl_rd && bank == BANK_W'(b)),
            .raddr     (cid),
            .rdata     (bank_rdata[b])
        );
    end

    // Register the response status and read steering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_fault    <= 1'b0;
            tbl_rd_q     <= 1'b0;
            ctrl_rd_q    <= 1'b0;
            bank_q       <= '0;
            ctrl_rdata_q <= '0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_fault    <= refuse;
            tbl_rd_q     <= tbl_rd;
            ctrl_rd_q    <= ctrl_rd;
            bank_q       <= bank;
            ctrl_rdata_q <= ctrl_rdata;
        end
    end

    // Select load data. Stores and refusals return zero.
    always_comb begin
        rsp_rdata = '0;
        if (tbl_rd_q)       rsp_rdata = bank_rdata[bank_q];
        else if (ctrl_rd_q) rsp_rdata = ctrl_rdata_q;
    end

endmodule

// File: rtl/ctac_checker.sv
// Checker for ctac_top: relates bus requests to the responses that follow them.
// Assumes the default address layout {alias, region, cid, bank}.
module ctac_checker #(
    parameter int NUM_BANKS = 8,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 11,
    parameter logic [2*NUM_BANKS-1:0] ZONE_MAP = 16'b00_00_01_01_01_01_10_10,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [2:0]        fault_reason
);

    logic              c_user, c_ctrl;
    logic [1:0]        c_zone;

    // Decode the request from the port fields.
    always_comb begin
        c_user = req_addr[ADDR_W-1];
        c_ctrl = req_addr[ADDR_W-2];
        c_zone = ZONE_MAP[req_addr[BANK_W-1:0]*2 +: 2];
    end

    // R1: every request gets a response in the next cycle.
    a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R1: no response appears without a request.
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R2: a system-alias store to a high-zone bank is refused.
    a_r2_high_zone: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !c_user && !c_ctrl && c_zone == 2'b10) |=> rsp_fault);
    // R3: a user-alias store outside the low zone is refused.
    a_r3_user_store: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && c_user && !c_ctrl && c_zone != 2'b00) |=> rsp_fault);
    // R5: refused responses carry no data.
    a_r5_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_rdata == '0);
    // R7: user access to the control region is refused.
    a_r7_user_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && c_user && c_ctrl) |=> rsp_fault);
    // R9: an allowed access leaves the recorded reason untouched.
    a_r9_reason_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> $stable(fault_reason));

endmodule

bind ctac_top ctac_checker #(
    .NUM_BANKS (NUM_BANKS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .ZONE_MAP  (ZONE_MAP)
) checker_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_rdata    (rsp_rdata),
    .fault_reason (fault_reason_w)
);

// File: tb/ctac_top_tb_top.sv
// Directed bench for ctac_top: one task per scenario, each checks its own results.
module ctac_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [10:0] req_addr;
    logic [31:0] req_wdata;
    logic [7:0]  req_pid;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_rdata;
    logic        hw_we;
    logic [5:0]  hw_cid;
    logic [2:0]  hw_bank;
    logic [31:0] hw_wdata;

    int checks = 0;
    int errors = 0;
    logic        got_fault;
    logic [31:0] got_data;

    always #2 clk = ~clk;

    ctac_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_pid(req_pid),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
        .hw_we(hw_we), .hw_cid(hw_cid), .hw_bank(hw_bank), .hw_wdata(hw_wdata)
    );

    function automatic logic [10:0] ta(input logic u, input int cid, input int bank);
        return {u, 1'b0, 6'(cid), 3'(bank)};
    endfunction

    function automatic logic [10:0] ca(input logic u, input int idx);
        return {u, 1'b1, 9'(idx)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus request. The response is sampled just after the capturing edge.
    task automatic bus(input logic w, input logic [10:0] a, input logic [31:0] d, input logic [7:0] pid);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_pid = pid;
        @(posedge clk); #1;
        got_fault = rsp_fault; got_data = rsp_rdata;
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd1);
        req_valid = 1'b0;
    endtask

    task automatic hw_write(input int cid, input int bank, input logic [31:0] d);
        @(negedge clk);
        hw_we = 1'b1; hw_cid = 6'(cid); hw_bank = 3'(bank); hw_wdata = d;
        @(posedge clk); #1;
        hw_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 rsp_valid idle", 32'(rsp_valid), 32'd0);
        bus(1'b0, ta(1'b0, 5, 3), '0, 8'h00);
        chk("R10 table zero", got_data, 32'd0);
        bus(1'b0, ca(1'b0, 0), '0, 8'h00);
        chk("R10 owner zero", got_data, 32'd0);
        bus(1'b0, ca(1'b0, 3), '0, 8'h00);
        chk("R10 reason zero", got_data, 32'd0);
    endtask

    task automatic t_kernel();
        bus(1'b1, ta(1'b0, 5, 2), 32'hA5A5_0001, 8'h00);
        chk("R2 mid store ok", 32'(got_fault), 32'd0);
        bus(1'b0, ta(1'b0, 5, 2), '0, 8'h00);
        chk("R1 readback", got_data, 32'hA5A5_0001);
        bus(1'b1, ta(1'b0, 5, 6), 32'h0000_0606, 8'h00);
        chk("R2 low store ok", 32'(got_fault), 32'd0);
        bus(1'b1, ta(1'b0, 5, 0), 32'hFFFF_FFFF, 8'h00);
        chk("R2 high store refused", 32'(got_fault), 32'd1);
        bus(1'b0, ta(1'b0, 5, 0), '0, 8'h00);
        chk("R2 high unchanged", got_data, 32'd0);
        bus(1'b0, ca(1'b0, 3), '0, 8'h00);
        chk("R2 reason 3", got_data, 32'd3);
        bus(1'b0, ca(1'b0, 2), '0, 8'h00);
        chk("R9 fault addr", got_data, 32'(ta(1'b0, 5, 0)));
    endtask

    task automatic t_owners();
        bus(1'b1, ca(1'b0, 0), 32'h11, 8'h00);
        bus(1'b1, ca(1'b0, 1), 32'h22, 8'h00);
        bus(1'b0, ca(1'b0, 1), '0, 8'h00);
        chk("R9 owner readback", got_data, 32'h22);
        bus(1'b0, ca(1'b0, 3), '0, 8'h00);
        chk("R9 reason held", got_data, 32'd3);
    endtask

    task automatic t_user();
        bus(1'b1, ta(1'b1, 3, 7), 32'h7777_0003, 8'h11);
        chk("R3 user low store ok", 32'(got_fault), 32'd0);
        bus(1'b0, ta(1'b0, 3, 7), '0, 8'h00);
        chk("R3 low stored", got_data, 32'h7777_0003);
        bus(1'b1, ta(1'b1, 3, 3), 32'hBAD0_0000, 8'h11);
        chk("R3 user mid refused", 32'(got_fault), 32'd1);
        bus(1'b0, ta(1'b0, 3, 3), '0, 8'h00);
        chk("R3 mid unchanged", got_data, 32'd0);
        bus(1'b0, ca(1'b0, 3), '0, 8'h00);
        chk("R3 reason 1", got_data, 32'd1);
        hw_write(3, 0, 32'hDEAD_0003);
        bus(1'b0, ta(1'b1, 3, 0), '0, 8'h11);
        chk("R4 user high read", got_data, 32'hDEAD_0003);
        chk("R8 hw high write", 32'(got_fault), 32'd0);
    endtask

    task automatic t_pages();
        bus(1'b0, ta(1'b1, 31, 7), '0, 8'h11);
        chk("R11 cid31 owner ok", 32'(got_fault), 32'd0);
        bus(1'b0, ta(1'b1, 32, 7), '0, 8'h11);
        chk("R11 cid32 refused", 32'(got_fault), 32'd1);
        chk("R5 refused data zero", got_data, 32'd0);
        bus(1'b0, ca(1'b0, 3), '0, 8'h00);
        chk("R5 reason 2", got_data, 32'd2);
        bus(1'b0, ta(1'b1, 32, 7), '0, 8'h22);
        chk("R11 cid32 other owner", 32'(got_fault), 32'd0);
    endtask

    task automatic t_prec();
        bus(1'b1, ta(1'b1, 3, 0), 32'h1, 8'h22);
        chk("R6 refused", 32'(got_fault), 32'd1);
        bus(1'b0, ca(1'b0, 3), '0, 8'h00);
        chk("R6 owner reason wins", got_data, 32'd2);
    endtask

    task automatic t_ctrl();
        bus(1'b0, ca(1'b1, 0), '0, 8'h11);
        chk("R7 user ctrl refused", 32'(got_fault), 32'd1);
        bus(1'b0, ca(1'b0, 3), '0, 8'h00);
        chk("R7 reason 4", got_data, 32'd4);
        bus(1'b0, ca(1'b0, 2), '0, 8'h00);
        chk("R9 ctrl fault addr", got_data, 32'(ca(1'b1, 0)));
    endtask

    task automatic t_collide();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = ta(1'b0, 9, 6);
        req_wdata = 32'h2222_2222; req_pid = 8'h00;
        hw_we = 1'b1; hw_cid = 6'd9; hw_bank = 3'd6; hw_wdata = 32'h1111_1111;
        @(posedge clk); #1;
        req_valid = 1'b0; hw_we = 1'b0;
        bus(1'b0, ta(1'b0, 9, 6), '0, 8'h00);
        chk("R8 hw wins collision", got_data, 32'h1111_1111);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_wdata = '0; req_pid = '0; hw_we = 1'b0; hw_cid = '0; hw_bank = '0; hw_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_kernel();
        t_owners();
        t_user();
        t_pages();
        t_prec();
        t_ctrl();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule